// File: doc/BRIEF.md
# Strided Strip-Mined Vector Address Generator

This block turns one vector memory request of arbitrary total element count into a stream of byte addresses, one per accepted handshake. The request carries a base byte address, a signed stride measured in elements, an element size code and a total element count. The byte step between neighbouring elements is the stride scaled by the element size. Consecutive addresses follow that step with no break in the arithmetic, across the whole request.

A vector register holds at most `MAXVL` elements (64 by default), so a long request is split into strips. The short leftover strip, holding the count modulo `MAXVL`, goes out first. Every later strip is full. When the count is an exact multiple, every strip is full. Before each strip, the block pulses `strip_start` for one cycle and places that strip's length on `vl_out`. A downstream load/store engine can then load its vector-length register before the strip's addresses arrive. `done` pulses once the final address has been taken. A request of zero elements completes at once and issues nothing.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset `addr_valid`, `strip_start`, `done` and `busy` are 0 and `vl_out` is 0.
- R2: Element k of a request (k counted from 0 across all strips) has address `base_addr + k * (sign_extend(stride) << elem_size)` modulo 2^ADDR_W. The `elem_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `stride` is two's complement, so a stride of 0 repeats the base and a negative stride walks downward.
- R3: When `strip_start` is high, `vl_out` equals the remaining count modulo `MAXVL`, or `MAXVL` when that remainder is 0. As a result, only the first strip can be short.
- R4: `strip_start` is high for exactly one cycle, with `addr_valid` low in that cycle. `addr_valid` is high in the cycle that follows.
- R5: Exactly `vl_out` addresses are accepted between one `strip_start` and the next `strip_start` or `done`.
- R6: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr_data` holds its value into the next cycle.
- R7: `done` is a one-cycle pulse in the cycle after the last address is accepted. `busy` is 0 from that cycle onward.
- R8: A `start` with `total_len` of 0 gives a `done` pulse in the next cycle, with no `strip_start` and no address.
- R9: `start` is ignored while `busy` is 1. A running request continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a request (taken only when idle) |
| base_addr | input | ADDR_W | Byte address of element 0 |
| stride | input | STRIDE_W | Signed element stride |
| elem_size | input | 2 | log2 of element size in bytes |
| total_len | input | LEN_W | Total element count |
| busy | output | 1 | Request in progress |
| strip_start | output | 1 | One-cycle pulse before each strip |
| vl_out | output | VL_W | Length of the current strip |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_data | output | ADDR_W | Element byte address |
| done | output | 1 | Pulse after the last address is accepted |

## Verification
Each counting rule is tried with a directed total length. A length of 0 exercises the empty-request path. A length of 1 is a lone short strip. Lengths of 63, 64 and 65 distinguish a short-only request, a full-only request and a one-element leftover ahead of a full strip. Lengths of 128 and 130 check several full strips with and without a leftover. Strides of 0, 1, a negative value and large random values, combined with all four element sizes, separate correct scaling and sign extension from plain counting. Random back-pressure on `addr_ready` shows that address values and strip counts do not depend on stall timing. A `start` pulse in the middle of a run checks that it cannot disturb the request.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_ISSUE = 2'd2
  } vag_state_e;
endpackage

// File: rtl/vag_incr.sv
// Registers the byte step: sign-extended element stride scaled by element size.
module vag_incr #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int ESZ_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [ESZ_W-1:0]    esz,
  output logic [ADDR_W-1:0]   incr
);
  logic [ADDR_W-1:0] ext;

  generate
    if (STRIDE_W >= ADDR_W) begin : g_trunc
      assign ext = stride[ADDR_W-1:0];
    end else begin : g_sext
      assign ext = {{(ADDR_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       incr <= '0;
    else if (load) incr <= ext << esz;
  end
endmodule

// File: rtl/vag_addr_acc.sv
// Address accumulator: loads base, adds the step on every accepted address.
module vag_addr_acc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] incr,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr + incr;
  end
endmodule

// File: rtl/vag_strip_ctl.sv
// Strip sequencer: remainder strip first, then full strips; handshake control.
module vag_strip_ctl
  import vag_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MAXVL = 64,
  localparam int LOG  = $clog2(MAXVL),
  localparam int VL_W = LOG + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             ready,
  output logic             launch,
  output logic             fire,
  output logic             valid,
  output logic             strip_start,
  output logic [VL_W-1:0]  vl,
  output logic             done,
  output logic             busy
);
  vag_state_e       state;
  logic [LEN_W-1:0] rem;
  logic [VL_W-1:0]  cnt;
  logic [LEN_W-1:0] rem_next;

  function automatic logic [VL_W-1:0] strip_len(input logic [LEN_W-1:0] r);
    if (r[LOG-1:0] == '0) return VL_W'(MAXVL);
    else                  return {1'b0, r[LOG-1:0]};
  endfunction

  assign busy     = (state != ST_IDLE);
  assign launch   = start && (state == ST_IDLE);
  assign fire     = valid && ready;
  assign rem_next = rem - LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rem         <= '0;
      cnt         <= '0;
      vl          <= '0;
      valid       <= 1'b0;
      strip_start <= 1'b0;
      done        <= 1'b0;
    end else begin
      strip_start <= 1'b0;
      done        <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (len == '0) begin
              done <= 1'b1;
            end else begin
              rem         <= len;
              vl          <= strip_len(len);
              cnt         <= strip_len(len);
              strip_start <= 1'b1;
              state       <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          valid <= 1'b1;
          state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (fire) begin
            rem <= rem_next;
            cnt <= cnt - VL_W'(1);
            if (cnt == VL_W'(1)) begin
              valid <= 1'b0;
              if (rem == LEN_W'(1)) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                vl          <= strip_len(rem_next);
                cnt         <= strip_len(rem_next);
                strip_start <= 1'b1;
                state       <= ST_ARM;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  sstart_then_valid_chk: assert property (@(posedge clk) disable iff (rst)
    strip_start |=> valid);
  // R4
  sstart_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    strip_start |-> !valid && !done);
  // R3
  vl_range_chk: assert property (@(posedge clk) disable iff (rst)
    strip_start |-> (vl != '0) && (vl <= VL_W'(MAXVL)));
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !valid && !busy);
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16,
  parameter int LEN_W    = 16,
  parameter int MAXVL    = 64,
  localparam int VL_W    = $clog2(MAXVL) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [1:0]          elem_size,
  input  logic [LEN_W-1:0]    total_len,
  output logic                busy,
  output logic                strip_start,
  output logic [VL_W-1:0]     vl_out,
  output logic                addr_valid,
  input  logic                addr_ready,
  output logic [ADDR_W-1:0]   addr_data,
  output logic                done
);
  logic              launch;
  logic              fire;
  logic [ADDR_W-1:0] incr;

  vag_strip_ctl #(.LEN_W(LEN_W), .MAXVL(MAXVL)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .len(total_len), .ready(addr_ready),
    .launch(launch), .fire(fire), .valid(addr_valid), .strip_start(strip_start),
    .vl(vl_out), .done(done), .busy(busy)
  );

  vag_incr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .ESZ_W(2)) u_incr (
    .clk(clk), .rst(rst), .load(launch), .stride(stride), .esz(elem_size),
    .incr(incr)
  );

  vag_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .load(launch), .step(fire), .base(base_addr),
    .incr(incr), .addr(addr_data)
  );

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_data));
endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] stride = '0;
  logic [1:0]  elem_size = '0;
  logic [15:0] total_len = '0;
  logic        busy, strip_start, addr_valid, done;
  logic [6:0]  vl_out;
  logic        addr_ready = 1'b0;
  logic [31:0] addr_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_addr_gen u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .stride(stride),
    .elem_size(elem_size), .total_len(total_len), .busy(busy),
    .strip_start(strip_start), .vl_out(vl_out), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_data(addr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [15:0] s,
                                           input logic [1:0] e, input int k);
    logic [31:0] inc;
    inc = {{16{s[15]}}, s} << e;
    return b + inc * k;
  endfunction

  function automatic int exp_len(input int r);
    return (r % 64 == 0) ? 64 : r % 64;
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [15:0] s, input logic [1:0] e,
                        input int len, input int rdy_pct, input bit poke);
    int  k = 0, in_strip = 0, cur_vl = 0, cyc = 0;
    bit  want_first = 0, last_fired = 0, finished = 0;
    @(negedge clk);
    base_addr = b; stride = s; elem_size = e; total_len = 16'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R8 done", done, 1);
      chk(!addr_valid && !strip_start, "R8 quiet", {addr_valid, strip_start}, 0);
      @(negedge clk);
      chk(!done && !busy, "R8 idle", {done, busy}, 0);
      return;
    end
    while (!finished && cyc < 5000) begin
      if (want_first) chk(addr_valid == 1'b1, "R4 first addr", addr_valid, 1);
      want_first = 0;
      if (last_fired) chk(done == 1'b1, "R7 done pulse", done, 1);
      if (strip_start) begin
        chk(!addr_valid, "R4 no valid", addr_valid, 0);
        if (k != 0) chk(in_strip == cur_vl, "R5 strip count", in_strip, cur_vl);
        cur_vl = exp_len(len - k);
        chk(int'(vl_out) == cur_vl, "R3 vl", vl_out, cur_vl);
        in_strip = 0;
        want_first = 1;
      end
      if (addr_valid)
        chk(addr_data == exp_addr(b, s, e, k), "R2 addr", addr_data, exp_addr(b, s, e, k));
      if (done) begin
        chk(k == len && !busy, "R7 done", k, len);
        chk(in_strip == cur_vl, "R5 last strip", in_strip, cur_vl);
        finished = 1;
      end
      // R6: a stalled address must reappear unchanged (k does not advance).
      addr_ready = ($urandom_range(99) < 32'(rdy_pct));
      last_fired = 0;
      if (addr_valid && addr_ready) begin
        k++; in_strip++;
        if (k == len) last_fired = 1;
      end
      // R9: start pulse with a different request while busy.
      if (poke && cyc == 3) begin
        start = 1'b1; base_addr = 32'hDEAD_0000; total_len = 16'd7; stride = 16'd3;
      end
      if (poke && cyc == 4) start = 1'b0;
      if (!finished) begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(finished, "R7 completion", finished, 1);
    addr_ready = 1'b0;
    @(negedge clk);
    chk(!done && !busy && !addr_valid, "R7 one-cycle", {done, busy, addr_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(!addr_valid && !strip_start && !done && !busy && vl_out == 0, "R1 reset",
        {addr_valid, strip_start, done, busy, vl_out}, 0);
    run_op(32'h0000_1000, 16'd1,      2'd3, 0,   100, 0);  // R8
    run_op(32'h0000_1000, 16'd1,      2'd3, 1,   100, 0);
    run_op(32'h0000_2000, 16'd1,      2'd2, 63,  100, 0);
    run_op(32'h0000_3000, 16'd2,      2'd0, 64,  60,  0);
    run_op(32'h0000_4000, 16'd1,      2'd3, 65,  100, 0);
    run_op(32'h0001_0000, 16'hFFFD,   2'd1, 130, 50,  0);  // R2 negative stride
    run_op(32'h0000_5000, 16'd0,      2'd2, 128, 70,  0);  // R2 zero stride
    run_op(32'h0000_6000, 16'd5,      2'd3, 70,  80,  1);  // R9
    run_op(32'hFFFF_FFF0, 16'd8,      2'd1, 20,  100, 0);  // R2 wrap
    for (int i = 0; i < 12; i++) begin
      run_op($urandom, 16'($urandom), 2'($urandom_range(3)),
             int'($urandom_range(300)), 30 + int'($urandom_range(70)), bit'($urandom_range(1)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule